// File: doc/BRIEF.md
# Relative Conditional Jump Unit

This block is the execute-stage logic for relative branches in a 16-bit processor. It receives the instruction word, the program counter that fetch has already moved past the jump instruction, the four status flags (zero, carry, negative, overflow) and a strobe marking the word as a valid jump. From the low ten bits of the word it forms a signed word displacement. It widens the displacement to address width, doubles it to get a byte distance, and adds it to the incremented PC.

A three-bit condition field, tested against the flags, decides whether the branch is taken. The block reports the chosen next PC and a taken flag. By default both outputs are registered, so a result appears one clock after its inputs. A parameter removes the register stage for a purely combinational variant.

Top module: `rel_jump_unit`

## Requirements
- R1: When taken, the next PC equals the incremented PC plus twice the low 10 instruction bits read as a two's complement number (bit 9 is the sign).
- R2: Condition field is instruction bits [12:10]; code 000 is taken when Z=0 and code 001 is taken when Z=1; whenever the branch is not taken the next PC equals the incremented PC.
- R3: Code 010 is taken when C=0 and code 011 is taken when C=1.
- R4: Code 100 is taken when N=1.
- R5: Code 101 is taken when N xor V is 0, and code 110 is taken when N xor V is 1.
- R6: Code 111 is taken regardless of the flags.
- R7: With the valid strobe low, the next PC equals the incremented PC and the taken flag is low, whatever the instruction and flags.
- R8: The target addition wraps modulo 2^16 in both directions with no overflow indication.
- R9: A displacement field of 0x3FF yields the incremented PC minus 2, which is the address of the jump itself.
- R10: Outputs are registered: a result appears after the next rising clock edge, and during reset the next PC is 0x0000 and the taken flag is low.
- R11: Instruction bits [15:13] have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 16 | Instruction word in execute |
| pc_inc_i | input | 16 | PC after the fetch increment |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| jmp_vld_i | input | 1 | Instruction is a valid relative jump |
| pc_next_o | output | 16 | Selected next PC |
| taken_o | output | 1 | Branch taken |

## Verification
The bench targets the sign bit of the displacement. A design that zero-extended the field would send negative displacements such as 0x3F0 and 0x200 far forward, and a design that left out the doubling would land on odd or halved addresses. It also checks the two signed-compare codes with N and V set in every combination that matters, because a design testing N alone instead of N xor V would get the overflowed cases wrong. Wraparound past 0xFFFF and below zero, the self-loop displacement, and a strobe held low under an always-taken word are all checked. The high opcode bits are varied to catch a decoder that reads the condition from the wrong field.

// File: rtl/rjmp_pkg.sv
package rjmp_pkg;

   // Condition codes carried in the instruction; order is decoded behaviour.
   typedef enum logic [2:0] {
      CC_ZCLR  = 3'b000,
      CC_ZSET  = 3'b001,
      CC_CCLR  = 3'b010,
      CC_CSET  = 3'b011,
      CC_NSET  = 3'b100,
      CC_SGE   = 3'b101,
      CC_SLT   = 3'b110,
      CC_ALWAYS = 3'b111
   } cond_e;

   typedef struct packed {
      logic z;
      logic c;
      logic n;
      logic v;
   } flags_t;

endpackage

// File: rtl/rjmp_offset_ext.sv
module rjmp_offset_ext #(
   parameter int INSN_W = 16,
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 10,
   parameter int SHIFT  = 1
) (
   input  logic [INSN_W-1:0] insn_i,
   output logic [ADDR_W-1:0] ofs_bytes_o
);

   localparam int EXT_W = ADDR_W - OFS_W;

   logic [OFS_W-1:0]  field;
   logic [ADDR_W-1:0] widened;

   assign field   = insn_i[OFS_W-1:0];
   assign widened = {{EXT_W{field[OFS_W-1]}}, field};

   generate
      if (SHIFT > 0) begin : g_scale
         assign ofs_bytes_o = {widened[ADDR_W-1-SHIFT:0], {SHIFT{1'b0}}};
      end else begin : g_noscale
         assign ofs_bytes_o = widened;
      end
   endgenerate

endmodule

// File: rtl/rjmp_cond_eval.sv
module rjmp_cond_eval
   import rjmp_pkg::*;
(
   input  cond_e  cond_i,
   input  flags_t flags_i,
   output logic   pass_o
);

   logic signed_lt;

   assign signed_lt = flags_i.n ^ flags_i.v;

   always_comb begin
      unique case (cond_i)
         CC_ZCLR:   pass_o = ~flags_i.z;
         CC_ZSET:   pass_o =  flags_i.z;
         CC_CCLR:   pass_o = ~flags_i.c;
         CC_CSET:   pass_o =  flags_i.c;
         CC_NSET:   pass_o =  flags_i.n;
         CC_SGE:    pass_o = ~signed_lt;
         CC_SLT:    pass_o =  signed_lt;
         CC_ALWAYS: pass_o = 1'b1;
         default:   pass_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/rjmp_target_add.sv
module rjmp_target_add #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] delta_i,
   output logic [ADDR_W-1:0] sum_o
);

   // Carry out discarded: address space wraps.
   logic [ADDR_W:0] full;

   assign full  = {1'b0, base_i} + {1'b0, delta_i};
   assign sum_o = full[ADDR_W-1:0];

endmodule

// File: rtl/rel_jump_unit.sv
module rel_jump_unit
   import rjmp_pkg::*;
#(
   parameter int          INSN_W   = 16,
   parameter int          ADDR_W   = 16,
   parameter int          OFS_W    = 10,
   parameter int          SHIFT    = 1,
   parameter int          COND_LSB = 10,
   parameter bit          OUT_REG  = 1'b1,
   parameter logic [15:0] RESET_PC = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [ADDR_W-1:0] pc_inc_i,
   input  logic              flag_z_i,
   input  logic              flag_c_i,
   input  logic              flag_n_i,
   input  logic              flag_v_i,
   input  logic              jmp_vld_i,
   output logic [ADDR_W-1:0] pc_next_o,
   output logic              taken_o
);

   localparam int COND_W   = 3;
   localparam int COND_MSB = COND_LSB + COND_W - 1;

   generate
      if (OFS_W + SHIFT > ADDR_W) begin : g_bad_ofs
         $error("rel_jump_unit: scaled displacement wider than address");
      end
      if (COND_MSB >= INSN_W) begin : g_bad_cond
         $error("rel_jump_unit: condition field outside instruction");
      end
      if (COND_LSB < OFS_W) begin : g_bad_overlap
         $error("rel_jump_unit: condition field overlaps displacement");
      end
   endgenerate

   logic [ADDR_W-1:0] ofs_bytes;
   logic [ADDR_W-1:0] target;
   logic              cond_pass;
   cond_e             cond;
   flags_t            flags;
   logic [ADDR_W-1:0] pc_sel;
   logic              take;

   assign cond  = cond_e'(insn_i[COND_MSB:COND_LSB]);
   assign flags = '{z: flag_z_i, c: flag_c_i, n: flag_n_i, v: flag_v_i};

   rjmp_offset_ext #(
      .INSN_W (INSN_W),
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W),
      .SHIFT  (SHIFT)
   ) u_ext (
      .insn_i      (insn_i),
      .ofs_bytes_o (ofs_bytes)
   );

   rjmp_target_add #(
      .ADDR_W (ADDR_W)
   ) u_add (
      .base_i  (pc_inc_i),
      .delta_i (ofs_bytes),
      .sum_o   (target)
   );

   rjmp_cond_eval u_cond (
      .cond_i  (cond),
      .flags_i (flags),
      .pass_o  (cond_pass)
   );

   assign take   = jmp_vld_i & cond_pass;
   assign pc_sel = take ? target : pc_inc_i;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_next_o <= ADDR_W'(RESET_PC);
               taken_o   <= 1'b0;
            end else begin
               pc_next_o <= pc_sel;
               taken_o   <= take;
            end
         end
      end else begin : g_comb
         assign pc_next_o = pc_sel;
         assign taken_o   = take;
      end
   endgenerate

endmodule

// File: rtl/rjmp_chk.sv
module rjmp_chk #(
   parameter int INSN_W   = 16,
   parameter int ADDR_W   = 16,
   parameter int OFS_W    = 10,
   parameter int SHIFT    = 1,
   parameter int COND_LSB = 10,
   parameter bit OUT_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [INSN_W-1:0] insn_i,
   input logic [ADDR_W-1:0] pc_inc_i,
   input logic              flag_z_i,
   input logic              flag_c_i,
   input logic              flag_n_i,
   input logic              flag_v_i,
   input logic              jmp_vld_i,
   input logic [ADDR_W-1:0] pc_next_o,
   input logic              taken_o
);

   logic [INSN_W-1:0] ins_q;
   logic [ADDR_W-1:0] pc_q;
   logic              z_q;
   logic              v_q;
   logic              hv;

   generate
      if (OUT_REG) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ins_q <= '0;
               pc_q  <= '0;
               z_q   <= 1'b0;
               v_q   <= 1'b0;
               hv    <= 1'b0;
            end else begin
               ins_q <= insn_i;
               pc_q  <= pc_inc_i;
               z_q   <= flag_z_i;
               v_q   <= jmp_vld_i;
               hv    <= 1'b1;
            end
         end
      end else begin : g_dir
         assign ins_q = insn_i;
         assign pc_q  = pc_inc_i;
         assign z_q   = flag_z_i;
         assign v_q   = jmp_vld_i;
         assign hv    = 1'b1;
      end
   endgenerate

   logic [ADDR_W-1:0] disp;
   logic [2:0]        cc_q;

   assign disp = ADDR_W'({{(ADDR_W-OFS_W){ins_q[OFS_W-1]}}, ins_q[OFS_W-1:0]}) << SHIFT;
   assign cc_q = ins_q[COND_LSB+2:COND_LSB];

   AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (hv && !v_q) |-> (!taken_o && pc_next_o == pc_q)); // R7

   AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (hv && taken_o) |-> (pc_next_o == ADDR_W'(pc_q + disp))); // R1

   AST_FALLTHROUGH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (hv && !taken_o) |-> (pc_next_o == pc_q)); // R2

   AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (hv && v_q && cc_q == 3'b111) |-> taken_o); // R6

   AST_EQ_FOLLOWS_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (hv && v_q && cc_q == 3'b001) |-> (taken_o == z_q)); // R2

endmodule

bind rel_jump_unit rjmp_chk #(
   .INSN_W   (INSN_W),
   .ADDR_W   (ADDR_W),
   .OFS_W    (OFS_W),
   .SHIFT    (SHIFT),
   .COND_LSB (COND_LSB),
   .OUT_REG  (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .insn_i    (insn_i),
   .pc_inc_i  (pc_inc_i),
   .flag_z_i  (flag_z_i),
   .flag_c_i  (flag_c_i),
   .flag_n_i  (flag_n_i),
   .flag_v_i  (flag_v_i),
   .jmp_vld_i (jmp_vld_i),
   .pc_next_o (pc_next_o),
   .taken_o   (taken_o)
);

// File: tb/sim_rel_jump_unit.sv
`timescale 1ns/1ps
module sim_rel_jump_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] insn = '0;
   logic [15:0] pc_inc = '0;
   logic        fz = 1'b0, fc = 1'b0, fn = 1'b0, fv = 1'b0;
   logic        vld = 1'b0;
   logic [15:0] pc_next;
   logic        taken;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rel_jump_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .insn_i    (insn),
      .pc_inc_i  (pc_inc),
      .flag_z_i  (fz),
      .flag_c_i  (fc),
      .flag_n_i  (fn),
      .flag_v_i  (fv),
      .jmp_vld_i (vld),
      .pc_next_o (pc_next),
      .taken_o   (taken)
   );

   // {insn, pc_inc, z,c,n,v, vld, exp_pc, exp_taken}
   localparam int NV = 17;
   localparam logic [53:0] VEC [NV] = '{
      {16'h2005, 16'h8000, 4'b0000, 1'b1, 16'h800A, 1'b1}, // R2 ne taken
      {16'h2005, 16'h8000, 4'b1000, 1'b1, 16'h8000, 1'b0}, // R2 ne not
      {16'h2410, 16'h1000, 4'b1000, 1'b1, 16'h1020, 1'b1}, // R2 eq taken
      {16'h2410, 16'h1000, 4'b0000, 1'b1, 16'h1000, 1'b0}, // R2 eq not
      {16'h2BF0, 16'h4000, 4'b0000, 1'b1, 16'h3FE0, 1'b1}, // R3 nc, R1 negative
      {16'h2BF0, 16'h4000, 4'b0100, 1'b1, 16'h4000, 1'b0}, // R3 nc not
      {16'h2C01, 16'h0200, 4'b0100, 1'b1, 16'h0202, 1'b1}, // R3 c taken
      {16'h2C01, 16'h0200, 4'b0000, 1'b1, 16'h0200, 1'b0}, // R3 c not
      {16'h3002, 16'h0100, 4'b0010, 1'b1, 16'h0104, 1'b1}, // R4 n taken
      {16'h3002, 16'h0100, 4'b0000, 1'b1, 16'h0100, 1'b0}, // R4 n not
      {16'h3404, 16'h0300, 4'b0011, 1'b1, 16'h0308, 1'b1}, // R5 ge n=v=1
      {16'h3404, 16'h0300, 4'b0010, 1'b1, 16'h0300, 1'b0}, // R5 ge n=1 v=0
      {16'h3A00, 16'h8000, 4'b0001, 1'b1, 16'h7C00, 1'b1}, // R5 lt v=1, R1
      {16'h3A00, 16'h8000, 4'b0000, 1'b1, 16'h8000, 1'b0}, // R5 lt not
      {16'h3DFF, 16'hFF00, 4'b1111, 1'b1, 16'h02FE, 1'b1}, // R6 R8 forward wrap
      {16'h3FFF, 16'h1234, 4'b0000, 1'b1, 16'h1232, 1'b1}, // R9 self loop
      {16'h3C05, 16'h5555, 4'b0000, 1'b0, 16'h5555, 1'b0}  // R7 strobe low
   };

   task automatic check(input string req, input logic [15:0] epc, input logic etk);
      n_run++;
      if (pc_next !== epc || taken !== etk) begin
         n_fail++;
         $display("FAIL %s: pc_next=%h taken=%b expected pc_next=%h taken=%b",
                  req, pc_next, taken, epc, etk);
      end
   endtask

   task automatic apply(input logic [15:0] i, input logic [15:0] p,
                        input logic [3:0] f, input logic v);
      @(negedge clk);
      insn = i; pc_inc = p; {fz, fc, fn, fv} = f; vld = v;
      @(posedge clk);
      #1;
   endtask

   initial begin
      // R10 reset state
      #1;
      check("R10", 16'h0000, 1'b0);
      insn = 16'h3C10; pc_inc = 16'h4000; vld = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R10", 16'h0000, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         apply(VEC[k][53:38], VEC[k][37:22], VEC[k][21:18], VEC[k][17]);
         check($sformatf("vector %0d (R1..)", k), VEC[k][16:1], VEC[k][0]);
      end

      // R8 backward wrap below zero: 0x0002 - 32
      apply(16'h3FF0, 16'h0002, 4'b0000, 1'b1);
      check("R8", 16'hFFE2, 1'b1);

      // R11 high bits differ, same result as 0x2005 case
      apply(16'hE005, 16'h8000, 4'b0000, 1'b1);
      check("R11", 16'h800A, 1'b1);
      apply(16'h4005, 16'h8000, 4'b1000, 1'b1);
      check("R11", 16'h8000, 1'b0);

      // R10 latency: new inputs not visible before the edge
      apply(16'h3C04, 16'h0400, 4'b0000, 1'b1);
      check("R10", 16'h0408, 1'b1);
      @(negedge clk);
      insn = 16'h3C10; pc_inc = 16'h2000; vld = 1'b1;
      #1;
      check("R10", 16'h0408, 1'b1);
      @(posedge clk);
      #1;
      check("R10", 16'h2020, 1'b1);

      // R7 strobe low with every flag set, L code
      apply(16'h3A00, 16'h6000, 4'b1111, 1'b0);
      check("R7", 16'h6000, 1'b0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule